// File: doc/BRIEF.md
# Timer Gate Control Unit

This unit decides, cycle by cycle, whether a companion counter may advance. It picks one of four gate sources: an asynchronous external pin, the overflow pulse of a neighbouring 8-bit timer, or either of two comparator outputs. A polarity bit then qualifies the chosen source, and the result drives a registered permit output. The counter itself, the comparators and the other timer all sit outside this unit.

Beyond plain level gating, two modes let software measure signals. Toggle mode flips an internal gate state on each active edge, so counting spans one full period of the source. Single-pulse mode uses a go/busy handshake. Software arms it, counting starts at the next active edge, and the trailing edge ends the measurement, clears the busy bit and freezes the count. With both modes enabled, the unit captures exactly one period and then halts.

A falling edge of the permit output sets a sticky event flag. A separate enable masks the flag onto an interrupt line.

Top module: `gate_ctrl`

## Requirements
- R1: While `gate_en` is low, `gate_open` is high from the next clock edge on, whatever the source does.
- R2: `src_sel` picks the source: 2'b00 the external pin, 2'b01 the timer overflow pulse, 2'b10 comparator 1, 2'b11 comparator 2. The pin passes through SYNC_STAGES flops before use, so with the default of 2 a pin change shows on `gate_open` after the third rising edge. Internal sources are used directly and show after the first edge. Sources that are not selected have no effect.
- R3: With `gate_pol` = 1 the qualified gate is active while the source is high. With `gate_pol` = 0 it is active while the source is low.
- R4: With `toggle_en` set (and single-pulse off), each rising edge of the qualified gate flips the gate state. `gate_open` therefore rises one edge after an active edge and falls one edge after the next one.
- R5: With `single_en` set, a `go_set` pulse sets `go_busy`. Counting stays off until the gate next goes active after the arming cycle, and `gate_open` stays low while armed and idle.
- R6: In single-pulse mode, the end of the measured pulse clears `go_busy` and drops `gate_open`. Later gate activity leaves `gate_open` low until `go_set` is pulsed again.
- R7: With both `toggle_en` and `single_en` set, exactly one full period of the source is counted. After that, `go_busy` clears and `gate_open` stays low.
- R8: `gate_open` is the readable gate status. It is 1 out of reset and is driven by a register updated each clock.
- R9: A 1-to-0 transition of `gate_open` sets the sticky `gate_flag` whatever the value of `irq_en`. `flag_clr` clears the flag, but a new fall in the same cycle wins over the clear. `gate_irq` = `gate_flag` AND `irq_en`.
- R10: Clearing `single_en` (or `gate_en`) clears `go_busy`. A `go_set` pulse while either is clear has no effect.
- R11: The toggle state returns to not-counting whenever `gate_en` or `toggle_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en | input | 1 | Enables gate control of counting |
| src_sel | input | 2 | Gate source select |
| gate_pol | input | 1 | Source polarity (1 = active high) |
| toggle_en | input | 1 | Toggle (period) mode |
| single_en | input | 1 | Single-pulse mode |
| go_set | input | 1 | One-cycle pulse that arms single-pulse capture |
| flag_clr | input | 1 | Clears the sticky gate flag |
| irq_en | input | 1 | Masks the flag onto the interrupt line |
| gate_pin | input | 1 | Asynchronous external gate pin |
| tmr_ovf | input | 1 | Overflow pulse of the neighbouring 8-bit timer |
| cmp1_out | input | 1 | Comparator 1 output |
| cmp2_out | input | 1 | Comparator 2 output |
| gate_open | output | 1 | Count permit and gate status |
| go_busy | output | 1 | Single-pulse go/busy bit |
| gate_flag | output | 1 | Sticky gate event flag |
| gate_irq | output | 1 | Masked gate interrupt |

## Verification
The bench builds the unit with the default SYNC_STAGES of 2. This fixes the pin-to-permit delay at three edges, so the bench can check that latency exactly and confirm that the pin path alone carries synchronizer stages. Comparator 1, with its one-edge delay, drives the table of level, toggle and single-pulse sequences, so each sequence can be predicted edge by edge. Directed tests then switch sources, toggle modes off mid-capture and test the flag's set-over-clear priority.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    GSRC_PIN  = 2'b00,
    GSRC_TOVF = 2'b01,
    GSRC_CMP1 = 2'b10,
    GSRC_CMP2 = 2'b11
  } gsrc_e;
endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/gate_src_sel.sv
module gate_src_sel
  import gate_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  input  logic             pin_sync,
  input  logic             tovf,
  input  logic             cmp1,
  input  logic             cmp2,
  output logic             qual
);
  logic raw;

  always_comb begin
    unique case (gsrc_e'(sel))
      GSRC_PIN:  raw = pin_sync;
      GSRC_TOVF: raw = tovf;
      GSRC_CMP1: raw = cmp1;
      GSRC_CMP2: raw = cmp2;
      default:   raw = pin_sync;
    endcase
  end

  assign qual = pol ? raw : ~raw;
endmodule

// File: rtl/gate_seq.sv
module gate_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic gen,
  input  logic tmode,
  input  logic smode,
  input  logic go_set,
  input  logic qual,
  output logic permit_nxt,
  output logic go_q
);
  logic qual_d, tgl_q, base_q, run_q;
  logic qual_rise, tgl_n, base_n, base_rise, base_fall;
  logic go_n, run_n;

  always_comb begin
    qual_rise = qual & ~qual_d;

    if (!gen || !tmode)  tgl_n = 1'b0;
    else if (qual_rise)  tgl_n = ~tgl_q;
    else                 tgl_n = tgl_q;

    base_n    = tmode ? tgl_n : qual;
    base_rise = base_n & ~base_q;
    base_fall = ~base_n & base_q;

    go_n  = go_q;
    run_n = run_q;
    if (!gen || !smode) begin
      go_n  = 1'b0;
      run_n = 1'b0;
    end else if (go_set) begin
      go_n  = 1'b1;
      run_n = 1'b0;
    end else if (go_q && !run_q && base_rise) begin
      run_n = 1'b1;
    end else if (go_q && run_q && base_fall) begin
      go_n  = 1'b0;
      run_n = 1'b0;
    end

    if (!gen)       permit_nxt = 1'b1;
    else if (smode) permit_nxt = run_n & base_n;
    else            permit_nxt = base_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_d <= 1'b0;
      tgl_q  <= 1'b0;
      base_q <= 1'b0;
      go_q   <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      qual_d <= qual;
      tgl_q  <= tgl_n;
      base_q <= base_n;
      go_q   <= go_n;
      run_q  <= run_n;
    end
  end
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             gate_pol,
  input  logic             toggle_en,
  input  logic             single_en,
  input  logic             go_set,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic             gate_pin,
  input  logic             tmr_ovf,
  input  logic             cmp1_out,
  input  logic             cmp2_out,
  output logic             gate_open,
  output logic             go_busy,
  output logic             gate_flag,
  output logic             gate_irq
);
  logic pin_s, qual, permit_nxt;

  gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(gate_pin), .d_out(pin_s)
  );

  gate_src_sel u_sel (
    .sel(src_sel), .pol(gate_pol), .pin_sync(pin_s), .tovf(tmr_ovf),
    .cmp1(cmp1_out), .cmp2(cmp2_out), .qual(qual)
  );

  gate_seq u_seq (
    .clk(clk), .rst_n(rst_n), .gen(gate_en), .tmode(toggle_en),
    .smode(single_en), .go_set(go_set), .qual(qual),
    .permit_nxt(permit_nxt), .go_q(go_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_open <= 1'b1;
      gate_flag <= 1'b0;
    end else begin
      gate_open <= permit_nxt;
      gate_flag <= (gate_open & ~permit_nxt) | (gate_flag & ~flag_clr);
    end
  end

  assign gate_irq = gate_flag & irq_en;
endmodule

// File: rtl/gate_ctrl_chk.sv
module gate_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_en,
  input logic single_en,
  input logic go_set,
  input logic flag_clr,
  input logic gate_open,
  input logic go_busy,
  input logic gate_flag
);
  p_open_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> gate_open);

  p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && single_en && go_set) |=> go_busy);

  p_idle_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate_en) && $past(single_en) && !go_busy) |-> !gate_open);

  p_halt_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(go_busy) && $past(gate_en) && $past(single_en)) |-> !gate_open);

  p_flag_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_open) |-> gate_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_flag && !flag_clr) |=> gate_flag);

  p_go_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !single_en |=> !go_busy);
endmodule

bind gate_ctrl gate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .single_en(single_en),
  .go_set(go_set), .flag_clr(flag_clr), .gate_open(gate_open),
  .go_busy(go_busy), .gate_flag(gate_flag)
);

// File: tb/tb_gate_ctrl.sv
`timescale 1ns/1ps
module tb_gate_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 0, gate_pol = 1, toggle_en = 0, single_en = 0;
  logic go_set = 0, flag_clr = 0, irq_en = 0;
  logic gate_pin = 0, tmr_ovf = 0, cmp1_out = 0, cmp2_out = 0;
  logic [1:0] src_sel = 2'b10;
  logic gate_open, go_busy, gate_flag, gate_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gate_ctrl dut (.*);

  // row: {gen, sel[1:0], pol, tmode, smode, go, clr, cmp1, exp_open, exp_go, exp_flag}
  localparam int NROW = 32;
  localparam logic [11:0] VEC [NROW] = '{
    12'b0_10_1_0_0_0_0_0_1_0_0, // 1  R1
    12'b1_10_1_0_0_0_0_0_0_0_1, // 2  R3 R9
    12'b1_10_1_0_0_0_0_1_1_0_1, // 3  R3
    12'b1_10_1_0_0_0_0_0_0_0_1, // 4  R9
    12'b1_10_1_0_0_0_1_0_0_0_0, // 5  R9
    12'b1_10_1_0_0_0_1_1_1_0_0, // 6
    12'b1_10_1_0_0_0_0_1_1_0_0, // 7
    12'b1_10_0_0_0_0_0_1_0_0_1, // 8  R3 pol 0
    12'b1_10_0_0_0_0_1_0_1_0_0, // 9  R3
    12'b1_10_1_1_0_0_0_0_0_0_1, // 10 R4
    12'b1_10_1_1_0_0_0_1_1_0_1, // 11 R4
    12'b1_10_1_1_0_0_1_0_1_0_0, // 12 R4
    12'b1_10_1_1_0_0_0_1_0_0_1, // 13 R4
    12'b1_10_1_1_0_0_1_0_0_0_0, // 14 R4
    12'b1_10_1_0_1_0_0_0_0_0_0, // 15 R5
    12'b1_10_1_0_1_1_0_1_0_1_0, // 16 R5
    12'b1_10_1_0_1_0_0_1_0_1_0, // 17 R5
    12'b1_10_1_0_1_0_0_0_0_1_0, // 18 R5
    12'b1_10_1_0_1_0_0_1_1_1_0, // 19 R5
    12'b1_10_1_0_1_0_0_1_1_1_0, // 20 R5
    12'b1_10_1_0_1_0_0_0_0_0_1, // 21 R6
    12'b1_10_1_0_1_0_0_1_0_0_1, // 22 R6
    12'b1_10_1_0_1_0_1_0_0_0_0, // 23 R6
    12'b1_10_1_0_1_0_0_1_0_0_0, // 24 R6
    12'b1_10_1_1_1_1_0_0_0_1_0, // 25 R7
    12'b1_10_1_1_1_0_0_1_1_1_0, // 26 R7
    12'b1_10_1_1_1_0_0_0_1_1_0, // 27 R7
    12'b1_10_1_1_1_0_0_1_0_0_1, // 28 R7
    12'b1_10_1_1_1_0_0_0_0_0_1, // 29 R7
    12'b1_10_1_1_1_0_0_1_0_0_1, // 30 R7
    12'b1_10_1_1_0_0_1_0_1_0_0, // 31 R4
    12'b0_10_1_1_0_0_0_0_1_0_0  // 32 R1
  };

  function automatic string row_tag(int i);
    if (i == 0 || i == 31) return "R1";
    if (i < 9)  return "R3/R9";
    if (i < 14) return "R4";
    if (i < 20) return "R5";
    if (i < 24) return "R6";
    if (i < 30) return "R7";
    return "R4";
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk("R8 reset open", gate_open, 1'b1);
    chk("R8 reset go", go_busy, 1'b0);
    chk("R9 reset flag", gate_flag, 1'b0);
    chk("R9 reset irq", gate_irq, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      logic [11:0] v;
      v = VEC[i];
      {gate_en, src_sel, gate_pol, toggle_en, single_en, go_set, flag_clr, cmp1_out} = v[11:3];
      tick();
      chk({row_tag(i), " open"}, gate_open, v[2]);
      chk({row_tag(i), " go"}, go_busy, v[1]);
      chk({row_tag(i), " flag"}, gate_flag, v[0]);
    end
    go_set = 0; flag_clr = 0;

    // R2: pin path through two sync stages
    gate_en = 1; src_sel = 2'b00; gate_pol = 1; toggle_en = 0; single_en = 0;
    gate_pin = 0; cmp1_out = 1;
    tick(); tick(); tick();
    chk("R2 pin low closed", gate_open, 1'b0);
    flag_clr = 1; tick(); flag_clr = 0;
    gate_pin = 1;
    tick(); chk("R2 pin edge1", gate_open, 1'b0);
    tick(); chk("R2 pin edge2", gate_open, 1'b0);
    tick(); chk("R2 pin edge3", gate_open, 1'b1);

    // R2: overflow source, pin ignored
    src_sel = 2'b01; gate_pin = 0; tmr_ovf = 1;
    tick(); chk("R2 ovf high", gate_open, 1'b1);
    tmr_ovf = 0; gate_pin = 1;
    tick(); chk("R2 ovf low", gate_open, 1'b0);

    // R2: comparator 2 selected, comparator 1 ignored
    src_sel = 2'b11; cmp1_out = 1; cmp2_out = 0;
    tick(); chk("R2 cmp2 low", gate_open, 1'b0);
    cmp1_out = 0; cmp2_out = 1;
    tick(); chk("R2 cmp2 high", gate_open, 1'b1);

    // R9: flag independent of irq_en, mask, set beats clear
    flag_clr = 1; tick(); flag_clr = 0;
    irq_en = 0; cmp2_out = 0;
    tick(); chk("R9 flag set unmasked", gate_flag, 1'b1);
    chk("R9 irq masked", gate_irq, 1'b0);
    irq_en = 1;
    tick(); chk("R9 irq enabled", gate_irq, 1'b1);
    cmp2_out = 1; tick();
    cmp2_out = 0; flag_clr = 1;
    tick(); chk("R9 set wins clear", gate_flag, 1'b1);
    tick(); chk("R9 clear", gate_flag, 1'b0);
    flag_clr = 0; irq_en = 0;

    // R10: clearing single mode clears go; go_set ignored without mode
    src_sel = 2'b10; cmp1_out = 0; single_en = 1; go_set = 1;
    tick(); chk("R10 armed", go_busy, 1'b1);
    go_set = 0; single_en = 0;
    tick(); chk("R10 mode off clears go", go_busy, 1'b0);
    go_set = 1;
    tick(); chk("R10 go ignored", go_busy, 1'b0);
    go_set = 0;

    // R11: toggle state cleared when toggle mode drops
    toggle_en = 1; cmp1_out = 0; tick();
    cmp1_out = 1; tick(); chk("R11 toggle on", gate_open, 1'b1);
    cmp1_out = 0; tick(); chk("R11 toggle hold", gate_open, 1'b1);
    toggle_en = 0; tick(); chk("R11 level mode", gate_open, 1'b0);
    toggle_en = 1; tick(); chk("R11 toggle reset", gate_open, 1'b0);

    // R1: disabling gate reopens regardless of source
    gate_en = 0; tick(); chk("R1 disabled", gate_open, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule